// File: doc/BRIEF.md
# Runaway Watchdog Timer with Selectable Response

The block watches for runaway software. A free-running prescaler divides the main clock, and a tick counter counts its ticks. Software configures the block through one 8-bit mode register and starts it by writing the run bit. After that, software must write the run bit again before the selected interval ends. If it misses the deadline, the block raises a runaway response. Depending on a response bit, that response is either a single-cycle system reset request or a non-maskable interrupt request that stays set until acknowledged.

There are eight intervals. Codes 0 to 6 select 2^(BASE_LOG2+code) clocks, and code 7 selects 2^(BASE_LOG2+8) clocks. The prescaler is never cleared, so a timeout can come up to one prescaler period (2^PRE_LOG2 clocks) early. Counting continues while the core is halted and freezes while the core is stopped. Once started, the block stays running and its configuration is locked until reset.

Top module: `wdt_runaway`

## Requirements
- R1: After reset the register reads 0x00 and both request outputs are low.
- R2: While stopped, a write with bit 7 = 0 stores bits 4:0 and they read back. The register read layout is {run[7], 0, 0, watchdog_en[4], nmi_sel[3], interval[2:0]}. A write with bit 7 = 1 starts the counter, and bit 7 then reads 1.
- R3: Any write with bit 7 = 1 while running clears the tick counter. Refreshing more often than the interval prevents any request.
- R4: With no refresh, the request appears N clocks after the starting write, where T-2^PRE_LOG2 < N <= T. T is 2^(BASE_LOG2+code) for codes 0..6 and 2^(BASE_LOG2+8) for code 7.
- R5: With bit 4 = 1 and bit 3 = 0, a timeout gives a one-cycle pulse on rst_req_o and no NMI. Counting restarts, so the next pulse follows exactly T clocks later.
- R6: With bit 4 = 1 and bit 3 = 1, a timeout sets nmi_req_o and no reset pulse. nmi_req_o stays high until nmi_ack_i is sampled high. Counting restarts at the event, so the next NMI comes exactly T clocks after the previous one.
- R7: With bit 4 = 0 the counter runs but never raises a request.
- R8: halt_i does not delay a timeout. Each clock with stop_i high freezes the prescaler and the counter, so the timeout is delayed by exactly that many clocks.
- R9: While running, writes with bit 7 = 0 are ignored, and bits 4:0 cannot change until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Mode register write strobe |
| wr_data_i | input | 8 | Mode register write data |
| rd_data_o | output | 8 | Mode register read data |
| halt_i | input | 1 | Core in halt state |
| stop_i | input | 1 | Core in stop state |
| nmi_ack_i | input | 1 | Clears the NMI request |
| rst_req_o | output | 1 | One-cycle system reset request |
| nmi_req_o | output | 1 | Non-maskable interrupt request level |

## Verification
A corrupted tick count or interval decode moves the request out of its window. That shows up on the first timeout, within T clocks of the starting write, and again on the next timeout, which must come exactly T clocks later. A wrong lock or run state shows on rd_data_o in the cycle after the offending write. A broken NMI hold or acknowledge shows on nmi_req_o one cycle after the acknowledge, or after any cycle without one. A missing freeze shifts the timeout by the length of the stop window.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int RUN_BIT  = 7;
  localparam int MODE_BIT = 4;
  localparam int RESP_BIT = 3;
  localparam int SEL_W    = 3;

  typedef struct packed {
    logic             run;
    logic             wd_en;
    logic             nmi_sel;
    logic [SEL_W-1:0] sel;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_LOG2 = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freeze_i,
  output logic tick_o
);
  logic [PRE_LOG2-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pre_q <= '0;
    else if (!freeze_i) pre_q <= pre_q + 1'b1;
  end

  assign tick_o = (&pre_q) & ~freeze_i;
endmodule

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output wdt_cfg_t   cfg_o,
  output logic       clear_o
);
  wdt_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i && !cfg_q.run) begin
      cfg_q.run     <= wr_data_i[RUN_BIT];
      cfg_q.wd_en   <= wr_data_i[MODE_BIT];
      cfg_q.nmi_sel <= wr_data_i[RESP_BIT];
      cfg_q.sel     <= wr_data_i[SEL_W-1:0];
    end
  end

  // start and refresh both clear the tick counter
  assign clear_o = wr_en_i & wr_data_i[RUN_BIT];
  assign cfg_o   = cfg_q;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int BASE_LOG2 = 12,
  parameter int PRE_LOG2  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clear_i,
  input  logic       tick_i,
  input  logic [2:0] sel_i,
  output logic       expire_o
);
  localparam int TOP_LOG2 = BASE_LOG2 + 8;
  localparam int CNT_W    = TOP_LOG2 - PRE_LOG2 + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1;
  logic [3:0]       sh;
  logic             at_lim;

  always_comb begin
    sh     = (sel_i == 3'd7) ? 4'd8 : {1'b0, sel_i};
    lim_m1 = (CNT_W'(1) << (BASE_LOG2 - PRE_LOG2 + int'(sh))) - CNT_W'(1);
  end

  assign at_lim   = (cnt_q == lim_m1);
  assign expire_o = run_i & tick_i & ~clear_i & at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_runaway.sv
module wdt_runaway
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2   = 12,
  parameter int PRE_LOG2    = 4,
  parameter bit HALT_FREEZE = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       halt_i,
  input  logic       stop_i,
  input  logic       nmi_ack_i,
  output logic       rst_req_o,
  output logic       nmi_req_o
);
  wdt_cfg_t cfg;
  logic     clear, tick, expire, freeze, runaway;
  logic     rst_req_q, nmi_q;

  generate
    if (HALT_FREEZE) begin : g_halt_frz
      assign freeze = stop_i | halt_i;
    end else begin : g_halt_run
      assign freeze = stop_i;
    end
  endgenerate

  wdt_cfg_reg u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .cfg_o(cfg), .clear_o(clear)
  );

  wdt_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk_i, .rst_ni, .freeze_i(freeze), .tick_o(tick)
  );

  wdt_counter #(.BASE_LOG2(BASE_LOG2), .PRE_LOG2(PRE_LOG2)) u_cnt (
    .clk_i, .rst_ni, .run_i(cfg.run), .clear_i(clear),
    .tick_i(tick), .sel_i(cfg.sel), .expire_o(expire)
  );

  assign runaway = expire & cfg.wd_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_q <= 1'b0;
      nmi_q     <= 1'b0;
    end else begin
      rst_req_q <= runaway & ~cfg.nmi_sel;
      nmi_q     <= (runaway & cfg.nmi_sel) | (nmi_q & ~nmi_ack_i);
    end
  end

  assign rst_req_o = rst_req_q;
  assign nmi_req_o = nmi_q;
  assign rd_data_o = {cfg.run, 2'b00, cfg.wd_en, cfg.nmi_sel, cfg.sel};
endmodule

// File: rtl/wdt_runaway_chk.sv
module wdt_runaway_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] rd_data_o,
  input logic       stop_i,
  input logic       nmi_ack_i,
  input logic       rst_req_o,
  input logic       nmi_req_o
);
  assert_rst_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  assert_rst_needs_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (rd_data_o[7] && rd_data_o[4] && !rd_data_o[3]));

  assert_nmi_needs_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_req_o) |-> (rd_data_o[7] && rd_data_o[4] && rd_data_o[3]));

  assert_nmi_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_req_o && !nmi_ack_i) |=> nmi_req_o);

  assert_run_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7] |=> rd_data_o[7]);

  assert_cfg_locked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7] |=> $stable(rd_data_o[4:0]));

  assert_no_event_in_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rst_req_o) || $rose(nmi_req_o)) |-> !$past(stop_i));
endmodule

bind wdt_runaway wdt_runaway_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_data_o(rd_data_o), .stop_i(stop_i),
  .nmi_ack_i(nmi_ack_i), .rst_req_o(rst_req_o), .nmi_req_o(nmi_req_o)
);

// File: tb/wdt_runaway_bench.sv
module wdt_runaway_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 6;
  localparam int PRE  = 2;
  localparam int PDIV = 1 << PRE;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       halt_i = 1'b0, stop_i = 1'b0, nmi_ack_i = 1'b0;
  logic       rst_req_o, nmi_req_o;

  int checks = 0;
  int failures = 0;

  wdt_runaway #(.BASE_LOG2(BASE), .PRE_LOG2(PRE)) u_wdt_runaway (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int exp_t(input int sel);
    return (sel == 7) ? (1 << (BASE + 8)) : (1 << (BASE + sel));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; wr_en_i = 0; halt_i = 0; stop_i = 0; nmi_ack_i = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  // counts edges after the last write until the selected output is seen
  task automatic measure(input bit use_nmi, input int limit, input int stop_at,
                         input int stop_len, input bit halt_rand,
                         output int n, output bit other_seen);
    n = 0; other_seen = 0;
    while (n < limit) begin
      @(negedge clk_i);
      stop_i = (n >= stop_at) && (n < stop_at + stop_len);
      halt_i = halt_rand ? 1'($urandom % 2) : 1'b0;
      @(posedge clk_i); #1;
      n++;
      if (use_nmi ? nmi_req_o : rst_req_o) break;
      if (use_nmi ? rst_req_o : nmi_req_o) other_seen = 1;
    end
    stop_i = 0; halt_i = 0;
  endtask

  task automatic chk_window(input int n, input int t, input int shift, input string tag);
    chk(n > t - PDIV + shift && n <= t + shift, tag, n, t + shift);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired (all R) actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    bit oth;
    void'($urandom(32'd4075));

    // R1
    do_reset();
    @(posedge clk_i); #1;
    chk(rd_data_o == 8'h00, "R1 rd", rd_data_o, 0);
    chk(!rst_req_o, "R1 rst_req", rst_req_o, 0);
    chk(!nmi_req_o, "R1 nmi", nmi_req_o, 0);

    // R2 config while stopped, then start
    wr(8'h1D);
    chk(rd_data_o == 8'h1D, "R2 store", rd_data_o, 8'h1D);
    wr(8'h0A);
    chk(rd_data_o == 8'h0A, "R2 rewrite", rd_data_o, 8'h0A);
    wr(8'h91);
    chk(rd_data_o == 8'h91, "R2 start", rd_data_o, 8'h91);

    // R9 lock while running
    do_reset();
    wr(8'h99);
    wr(8'h00);
    chk(rd_data_o == 8'h99, "R9 zero write", rd_data_o, 8'h99);
    wr(8'h12);
    chk(rd_data_o == 8'h99, "R9 cfg write", rd_data_o, 8'h99);
    wr(8'hA4);
    chk(rd_data_o == 8'h99, "R9 refresh write", rd_data_o, 8'h99);

    // R4 / R5 every interval code, reset response
    for (int s = 0; s < 8; s++) begin
      do_reset();
      wr(8'h90 | 8'(s));
      measure(1'b0, exp_t(s) + 8, 1 << 30, 0, 1'b0, n, oth);
      chk_window(n, exp_t(s), 0, $sformatf("R4 code%0d", s));
      chk(!oth, "R5 no nmi", oth, 0);
      @(posedge clk_i); #1;
      chk(!rst_req_o, "R5 pulse width", rst_req_o, 0);
      measure(1'b0, exp_t(s) + 8, 1 << 30, 0, 1'b0, n, oth);
      chk(n == exp_t(s) - 1, "R5 restart period", n + 1, exp_t(s));
    end

    // R6 NMI level, ack, restart
    do_reset();
    wr(8'h98);
    measure(1'b1, 80, 1 << 30, 0, 1'b0, n, oth);
    chk_window(n, exp_t(0), 0, "R6 window");
    chk(!oth, "R6 no rst_req", oth, 0);
    n = 0;
    while (n < 200) begin
      @(negedge clk_i) nmi_ack_i = (n == 20);
      @(posedge clk_i); #1;
      n++;
      if (n <= 20) chk(nmi_req_o, "R6 hold", nmi_req_o, 1);
      if (n == 21) chk(!nmi_req_o, "R6 ack clears", nmi_req_o, 0);
      if (rst_req_o) chk(0, "R6 stray rst_req", 1, 0);
      if (n > 21 && nmi_req_o) break;
    end
    nmi_ack_i = 0;
    chk(n == exp_t(0), "R6 restart period", n, exp_t(0));

    // R7 watchdog mode off
    do_reset();
    wr(8'h88);
    measure(1'b1, 3 * exp_t(0), 1 << 30, 0, 1'b0, n, oth);
    chk(n == 3 * exp_t(0) && !oth, "R7 no request", {30'd0, oth, nmi_req_o}, 0);
    chk(rd_data_o[7], "R7 still running", rd_data_o[7], 1);

    // R3 refresh keeps it quiet
    do_reset();
    wr(8'h90);
    oth = 0;
    for (int k = 0; k < 10; k++) begin
      repeat (40) begin
        @(posedge clk_i); #1;
        if (rst_req_o || nmi_req_o) oth = 1;
      end
      wr(8'h90);
      if (rst_req_o || nmi_req_o) oth = 1;
    end
    chk(!oth, "R3 refresh", oth, 0);
    measure(1'b0, 80, 1 << 30, 0, 1'b0, n, oth);
    chk_window(n, exp_t(0), 0, "R3 after last refresh");

    // R8 halt no effect, stop freezes
    do_reset();
    wr(8'h92);
    measure(1'b0, 300, 1 << 30, 0, 1'b1, n, oth);
    chk_window(n, exp_t(2), 0, "R8 halt");
    do_reset();
    wr(8'h92);
    measure(1'b0, 340, 10, 37, 1'b1, n, oth);
    chk_window(n, exp_t(2), 37, "R8 stop");

    // random mix
    for (int t = 0; t < 6; t++) begin
      int s;
      bit r;
      s = int'($urandom % 5);
      r = 1'($urandom % 2);
      do_reset();
      wr(8'h90 | (8'(r) << 3) | 8'(s));
      measure(r, exp_t(s) + 8, 1 << 30, 0, 1'b1, n, oth);
      chk_window(n, exp_t(s), 0, r ? "R6 random" : "R5 random");
      chk(!oth, "R4 random other output", oth, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule